// File: doc/BRIEF.md
# Prescaled Trigger Decision Unit

This block turns a vector of algorithm bits into one trigger decision per bunch crossing. A valid strobe marks each crossing. Every algorithm bit first goes through its own prescaler, which lets only every Nth occurrence through. Each algorithm also keeps a saturating count of the occurrences that its prescaler passed.

Two per-algorithm masks shape the decision. A participation mask chooses which passed algorithms may raise the decision. A veto mask chooses which passed algorithms force it low. The decision is registered and appears a fixed two cycles after the strobe.

Software uses a small write port to set the prescale factors and mask bits and to clear counters, and a read port to sample any counter. A bunch-crossing reset input puts every prescaler back to the start of its cycle.

Top module: `trig_decision_top`

## Requirements
- R1: After reset, `final_valid` and `final_or` are 0, every counter reads 0, every prescale factor is 1 and both mask bits of every algorithm are 0.
- R2: `final_valid` is 1 in the cycle that follows the second rising edge after a cycle with `in_valid` high, and is 0 otherwise. `final_or` is 0 whenever `final_valid` is 0.
- R3: With prescale factor N≥1, an algorithm passes on every Nth strobe in which its bit is 1, counted from the last pass or phase reset. N=1 passes each occurrence. N=0 passes none and leaves the phase unchanged.
- R4: An algorithm's counter increments by one for each passed occurrence. The mask settings do not affect it.
- R5: A counter at its maximum of 2^CNT_W-1 holds that value.
- R6: A clear command sets the selected counter to 0 and wins over an increment in the same cycle.
- R7: For a strobe, `final_or` is 1 exactly when at least one passed algorithm has its participation bit set and no passed algorithm has its veto bit set.
- R8: A configuration write takes effect from the first strobe in a later cycle. A strobe in the same cycle as the write still uses the old setting.
- R9: `bc_rst` returns every prescaler phase to zero. A strobe in the same cycle is evaluated from phase zero.
- R10: When `cfg_we` is 1, `cfg_op` selects the action on algorithm `cfg_idx`: 0 loads the prescale factor from `cfg_wdata`, 1 sets the participation bit to `cfg_wdata[0]`, 2 sets the veto bit to `cfg_wdata[0]`, 3 clears the counter. Writes with `cfg_idx` ≥ NUM_ALGO are ignored.
- R11: `rd_cnt` shows, in the same cycle, the counter of algorithm `rd_idx`, or 0 if `rd_idx` ≥ NUM_ALGO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a crossing whose algorithm bits are valid |
| algo_bits | input | NUM_ALGO | Algorithm bits for the crossing |
| bc_rst | input | 1 | Bunch-crossing reset; clears the prescaler phases |
| cfg_we | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | Command: 0 prescale, 1 participation, 2 veto, 3 clear counter |
| cfg_idx | input | IDX_W | Algorithm the command targets |
| cfg_wdata | input | PS_W | Prescale factor, or mask value in bit 0 |
| rd_idx | input | IDX_W | Counter to read |
| rd_cnt | output | CNT_W | Value of the selected counter |
| final_valid | output | 1 | Decision slot valid |
| final_or | output | 1 | Trigger decision |

## Verification
A strobe driven before rising edge k produces its decision after edge k+1. The bench therefore compares `final_valid` and `final_or` at each falling edge with a two-deep history of expected values, and it does this even when strobes arrive back to back. Counter and configuration effects are due one edge after the stimulus that causes them. Because the counter read is combinational, the bench reads counters at each falling edge before it drives the next stimulus, and compares them with a model that has applied everything driven up to the previous edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        OP_PRESCALE = 2'd0,
        OP_PART_EN  = 2'd1,
        OP_VETO_EN  = 2'd2,
        OP_CNT_CLR  = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/trig_algo_slice.sv
module trig_algo_slice
    import trig_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic             strobe_i,
    input  logic             bc_rst_i,
    input  logic             wr_i,
    input  logic [1:0]       op_i,
    input  logic [PS_W-1:0]  wdata_i,
    output logic             part_hit_o,
    output logic             veto_hit_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PS_W:0]    ONE_EXT = 1;

    typedef struct packed {
        logic [PS_W-1:0]  factor;
        logic             part_en;
        logic             veto_en;
        logic [PS_W-1:0]  phase;
        logic [CNT_W-1:0] cnt;
        logic             part_hit;
        logic             veto_hit;
    } slice_t;

    slice_t          st_d, st_q;
    logic            pass;
    logic [PS_W-1:0] phase_base;

    always_comb begin
        st_d       = st_q;
        pass       = 1'b0;
        phase_base = bc_rst_i ? '0 : st_q.phase;
        st_d.phase = phase_base;
        if (strobe_i && bit_i && (st_q.factor != '0)) begin
            if (({1'b0, phase_base} + ONE_EXT) >= {1'b0, st_q.factor}) begin
                pass       = 1'b1;
                st_d.phase = '0;
            end else begin
                st_d.phase = phase_base + 1'b1;
            end
        end
        if (pass && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.part_hit = pass & st_q.part_en;
        st_d.veto_hit = pass & st_q.veto_en;
        if (wr_i) begin
            case (cfg_op_e'(op_i))
                OP_PRESCALE: st_d.factor  = wdata_i;
                OP_PART_EN:  st_d.part_en = wdata_i[0];
                OP_VETO_EN:  st_d.veto_en = wdata_i[0];
                default:     st_d.cnt     = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.factor <= PS_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign part_hit_o = st_q.part_hit;
    assign veto_hit_o = st_q.veto_hit;
    assign cnt_o      = st_q.cnt;

    logic clr_now;
    assign clr_now = wr_i && (op_i == OP_CNT_CLR);

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_now |=> (st_q.cnt >= $past(st_q.cnt))); // R4
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr_now) |=> (st_q.cnt == CNT_MAX)); // R5
    AST_BLOCKED_ALGO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.factor == '0 && !clr_now) |=> ($stable(st_q.cnt) && !st_q.part_hit)); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (st_q.cnt == '0)); // R6
endmodule

// File: rtl/trig_decision_stage.sv
module trig_decision_stage #(
    parameter int NUM_ALGO = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [NUM_ALGO-1:0] part_vec_i,
    input  logic [NUM_ALGO-1:0] veto_vec_i,
    output logic                final_valid_o,
    output logic                final_or_o
);
    typedef struct packed {
        logic stage1_v;
        logic out_v;
        logic out_or;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d          = dec_q;
        dec_d.stage1_v = in_valid_i;
        dec_d.out_v    = dec_q.stage1_v;
        dec_d.out_or   = dec_q.stage1_v & (|part_vec_i) & ~(|veto_vec_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign final_valid_o = dec_q.out_v;
    assign final_or_o    = dec_q.out_or;

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ##1 final_valid_o); // R2
    AST_QUIET_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !final_valid_o |-> !final_or_o); // R2
    AST_VETO_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.stage1_v && (|veto_vec_i)) |=> !final_or_o); // R7
endmodule

// File: rtl/trig_decision_top.sv
module trig_decision_top
    import trig_pkg::*;
#(
    parameter int NUM_ALGO = 128,
    parameter int PS_W     = 8,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(NUM_ALGO) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [NUM_ALGO-1:0] algo_bits,
    input  logic                bc_rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_op,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [PS_W-1:0]     cfg_wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic                final_valid,
    output logic                final_or
);
    logic [NUM_ALGO-1:0] part_vec;
    logic [NUM_ALGO-1:0] veto_vec;
    logic [CNT_W-1:0]    cnt_arr [NUM_ALGO];

    for (genvar g = 0; g < NUM_ALGO; g++) begin : g_slice
        logic wr_sel;
        assign wr_sel = cfg_we && (cfg_idx == IDX_W'(g));
        trig_algo_slice #(
            .PS_W (PS_W),
            .CNT_W(CNT_W)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_i     (algo_bits[g]),
            .strobe_i  (in_valid),
            .bc_rst_i  (bc_rst),
            .wr_i      (wr_sel),
            .op_i      (cfg_op),
            .wdata_i   (cfg_wdata),
            .part_hit_o(part_vec[g]),
            .veto_hit_o(veto_vec[g]),
            .cnt_o     (cnt_arr[g])
        );
    end

    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < NUM_ALGO; i++) begin
            if (rd_idx == IDX_W'(i)) rd_cnt = cnt_arr[i];
        end
    end

    trig_decision_stage #(
        .NUM_ALGO(NUM_ALGO)
    ) u_decision (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid_i   (in_valid),
        .part_vec_i   (part_vec),
        .veto_vec_i   (veto_vec),
        .final_valid_o(final_valid),
        .final_or_o   (final_or)
    );

    AST_NO_HIT_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (part_vec == '0 && veto_vec == '0)); // R7
endmodule

// File: tb/trig_decision_top_bench.sv
module trig_decision_top_bench;
    localparam int NA    = 16;
    localparam int PS_W  = 4;
    localparam int CNT_W = 8;
    localparam int IW    = $clog2(NA) + 1;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NA-1:0] algo_bits = '0;
    logic          bc_rst = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [PS_W-1:0] cfg_wdata = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [CNT_W-1:0] rd_cnt;
    logic          final_valid, final_or;

    always #5 clk = ~clk;

    trig_decision_top #(.NUM_ALGO(NA), .PS_W(PS_W), .CNT_W(CNT_W)) u_trig_decision_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .algo_bits(algo_bits),
        .bc_rst(bc_rst), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rd_idx(rd_idx), .rd_cnt(rd_cnt),
        .final_valid(final_valid), .final_or(final_or)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R1";
    int rdsel = 0;

    int m_ps [NA];
    int m_part [NA];
    int m_veto [NA];
    int m_ph [NA];
    int m_cnt [NA];
    logic h0_v = 0, h0_f = 0, h1_v = 0, h1_f = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_pass(input int i, input logic v, input logic b, input logic bcr);
        logic p = 1'b0;
        if (bcr) m_ph[i] = 0;
        if (v && b && m_ps[i] != 0) begin
            if (m_ph[i] + 1 >= m_ps[i]) begin p = 1'b1; m_ph[i] = 0; end
            else m_ph[i] = m_ph[i] + 1;
        end
        return p;
    endfunction

    task automatic step(input logic v, input logic [NA-1:0] b, input logic we,
                        input int op, input int idx, input int wd, input logic bcr);
        logic any_part, any_veto, p;
        @(negedge clk);
        chk("R2", int'(final_valid), int'(h1_v));
        chk("R7", int'(final_or), int'(h1_f));
        h1_v = h0_v; h1_f = h0_f;
        rd_idx = IW'(rdsel);
        #1;
        chk(phase, int'(rd_cnt), (rdsel < NA) ? m_cnt[rdsel] : 0);
        in_valid = v; algo_bits = b; bc_rst = bcr;
        cfg_we = we; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_wdata = PS_W'(wd);
        any_part = 0; any_veto = 0;
        for (int i = 0; i < NA; i++) begin
            p = model_pass(i, v, b[i], bcr);
            if (p && m_cnt[i] != CMAX) m_cnt[i]++;
            if (p && m_part[i] != 0) any_part = 1;
            if (p && m_veto[i] != 0) any_veto = 1;
        end
        if (we && idx < NA) begin
            case (op)
                0: m_ps[idx] = wd;
                1: m_part[idx] = wd & 1;
                2: m_veto[idx] = wd & 1;
                default: m_cnt[idx] = 0;
            endcase
        end
        h0_v = v; h0_f = v && any_part && !any_veto;
    endtask

    task automatic strobe(input logic [NA-1:0] b);
        step(1'b1, b, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic wr(input int op, input int idx, input int wd);
        step(1'b0, '0, 1'b1, op, idx, wd, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < NA; i++) begin
            m_ps[i] = 1; m_part[i] = 0; m_veto[i] = 0; m_ph[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(final_valid), 0);
        chk("R1", int'(final_or), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NA; i++) begin
            rdsel = i;
            step(1'b0, '0, 1'b0, 0, 0, 0, 1'b0);
        end

        // R10 / R7: masks, veto and ignored out-of-range index
        phase = "R10";
        rdsel = 0;
        wr(1, 0, 1);
        wr(2, 1, 1);
        wr(1, NA + 3, 1);
        strobe(16'h0001);
        strobe(16'h0003);
        strobe(16'h0002);
        strobe(16'h0000);
        strobe(16'h0008);
        rdsel = NA + 2;
        strobe(16'h0001);

        // R3: prescale factors 3 and 0
        phase = "R3";
        rdsel = 0;
        wr(0, 0, 3);
        repeat (7) strobe(16'h0001);
        wr(0, 4, 0);
        wr(1, 4, 1);
        rdsel = 4;
        repeat (4) strobe(16'h0010);

        // R9: phase reset
        phase = "R9";
        rdsel = 0;
        strobe(16'h0001);
        step(1'b1, 16'h0001, 1'b0, 0, 0, 0, 1'b1);
        strobe(16'h0001);
        strobe(16'h0001);
        strobe(16'h0001);

        // R8: write coinciding with strobe
        phase = "R8";
        step(1'b1, 16'h0001, 1'b1, 0, 0, 1, 1'b0);
        strobe(16'h0001);
        step(1'b1, 16'h0001, 1'b1, 1, 0, 0, 1'b0);
        strobe(16'h0001);
        wr(1, 0, 1);

        // R6: clear racing an increment
        phase = "R6";
        step(1'b1, 16'h0001, 1'b1, 3, 0, 0, 1'b0);
        strobe(16'h0001);
        wr(3, 0, 0);

        // R5: saturation
        phase = "R5";
        rdsel = 2;
        repeat (CMAX + 6) strobe(16'h0004);
        wr(3, 2, 0);

        // R4 / R11: random mix
        phase = "R4";
        for (int n = 0; n < 3000; n++) begin
            logic v, we, bcr;
            logic [NA-1:0] b;
            int op, idx, wd;
            v   = ($urandom % 2) == 0;
            b   = NA'($urandom) & NA'($urandom);
            we  = ($urandom % 5) == 0;
            op  = $urandom % 4;
            idx = $urandom % (NA + 4);
            wd  = (op == 0) ? ($urandom % 6) : ($urandom % 2);
            if (op == 3 && ($urandom % 4) != 0) we = 1'b0;
            bcr = ($urandom % 50) == 0;
            rdsel = n % (NA + 1);
            if (rdsel == NA) phase = "R11"; else phase = "R4";
            step(v, b, we, op, idx, wd, bcr);
        end
        phase = "R2";
        rdsel = 0;
        repeat (3) step(1'b0, '0, 1'b0, 0, 0, 0, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule